// File: doc/BRIEF.md
# Sprite and Sample DMA Arbiter

This block takes the system bus away from a stalled processor and moves data on its behalf for two kinds of request. A sprite request copies a whole page of bytes, one byte at a time, from a base page in memory to a single fixed write port of the sprite memory. A sample request fetches one byte from a given address and hands it to the audio buffer through a one-cycle load strobe. Both kinds share one bus and one parity scheme: reads happen only on even bus cycles and writes only on odd ones. A sample fetch slots in between sprite steps, but only after its own halt and alignment cycles have elapsed.

While the block owns the bus, any cycle that moves no data repeats a read of the address the processor was stalled on. This keeps the bus activity the processor would have produced. The exceptions are the two controller-port addresses, where a repeated read would shift input data and is therefore dropped. The processor gets the bus back one cycle after the last pending transfer completes.

Top module: `dma_arb`

## Requirements
- R1: While reset is held, and after it while no request is pending, busOwn, busRd, busWr, sprDone and smpLoad are all low.
- R2: The first cycle in which the block takes the bus after a request is a read of stallAddr. This read happens even when stallAddr is a controller-port address.
- R3: Sprite and sample data reads occur only on even cycles. The first cycle after reset release counts as even, and parity alternates every clock.
- R4: A sample request arms a halt flag and an alignment flag. Each owned cycle, including the entry cycle, clears one of them, halt first. The sample read of the latched smpAddr happens on the first even owned cycle with both flags clear. One cycle later smpLoad pulses for one cycle, and smpData holds the byte read.
- R5: A sprite get on an even cycle reads address {sprPage, offset}, where the offset starts at 0 and increments per get. A put on an odd cycle, when the sprite step count is odd, writes the last byte read to address 0x2004.
- R6: A sprite transfer ends after 2*SPR_LEN steps (SPR_LEN gets and SPR_LEN puts). sprDone pulses for one cycle in the cycle after the final put.
- R7: An owned cycle that carries no transfer reads stallAddr again. When stallAddr is 0x4016 or 0x4017, that read is dropped and busRd stays low.
- R8: On an even cycle, an eligible sample read takes precedence over a sprite get. The sprite transfer then resumes with its next offset.
- R9: busOwn falls in the cycle after both transfer kinds become idle. A new request of a kind that is already pending is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| stallAddr | input | ADDR_W | Address of the processor access being stalled |
| sprReq | input | 1 | Pulse requesting a sprite page copy |
| sprPage | input | ADDR_W-log2(SPR_LEN) | Source page, latched with sprReq |
| smpReq | input | 1 | Pulse requesting a single sample fetch |
| smpAddr | input | ADDR_W | Sample address, latched with smpReq |
| busOwn | output | 1 | Block owns the bus; processor is halted |
| busRd | output | 1 | Bus read strobe |
| busWr | output | 1 | Bus write strobe |
| busAddr | output | ADDR_W | Bus address |
| busWdata | output | DATA_W | Bus write data |
| busRdata | input | DATA_W | Bus read data, valid in the same cycle as busRd |
| sprDone | output | 1 | One-cycle pulse when a sprite copy finishes |
| smpLoad | output | 1 | One-cycle pulse loading smpData into the audio buffer |
| smpData | output | DATA_W | Fetched sample byte |

## Verification
The bench builds the block with SPR_LEN set to 32 and keeps the default port and controller-port addresses. The short page means a full copy takes about 65 cycles. That makes it affordable to start sprite copies on both parities, to inject a sample fetch mid-copy, to issue both requests in the same cycle, and to stall on either controller-port address. All of these run against a behavioural model that is compared on every clock.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  typedef struct packed {
    logic entry;     // first owned cycle: read of stalled address
    logic smpGo;     // sample read this cycle
    logic sprGet;    // sprite read this cycle
    logic sprPut;    // sprite write this cycle
    logic align;     // owned cycle without transfer
    logic sprStart;  // latch sprite page
    logic smpStart;  // latch sample address
  } dmaStrobe_t;
endpackage

// File: rtl/dma_arb_ctl.sv
module dma_arb_ctl
  import dma_arb_pkg::*;
#(
  parameter int SPR_LEN = 256
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sprReq,
  input  logic       smpReq,
  output dmaStrobe_t stb,
  output logic       busOwn,
  output logic       sprDone
);
  localparam int CNT_W = $clog2(2 * SPR_LEN);
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(2 * SPR_LEN - 1);

  logic cycOdd, active, sprActive, smpPend, haltPend, dummyPend;
  logic [CNT_W-1:0] sprCnt;
  logic pend, entry, smpGo, sprGet, sprPut, align, lastPut;
  logic sprStart, smpStart, nextSpr, nextSmp;

  always_comb begin
    pend     = sprActive | smpPend;
    entry    = !active & pend;
    smpGo    = active & !cycOdd & smpPend & !haltPend & !dummyPend;
    sprGet   = active & !cycOdd & !smpGo & sprActive;
    sprPut   = active & cycOdd & sprActive & sprCnt[0];
    align    = active & !smpGo & !sprGet & !sprPut;
    lastPut  = sprPut & (sprCnt == LAST_STEP);
    sprStart = sprReq & !sprActive;
    smpStart = smpReq & !smpPend;
    nextSpr  = sprStart | (sprActive & !lastPut);
    nextSmp  = smpStart | (smpPend & !smpGo);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cycOdd    <= 1'b0;
      active    <= 1'b0;
      sprActive <= 1'b0;
      smpPend   <= 1'b0;
      haltPend  <= 1'b0;
      dummyPend <= 1'b0;
      sprCnt    <= '0;
      sprDone   <= 1'b0;
    end else begin
      cycOdd    <= ~cycOdd;
      sprActive <= nextSpr;
      smpPend   <= nextSmp;
      active    <= (entry | active) & (nextSpr | nextSmp);
      sprDone   <= lastPut;
      if (smpStart) begin
        haltPend  <= 1'b1;
        dummyPend <= 1'b1;
      end else if (entry | active) begin
        if (haltPend) haltPend <= 1'b0;
        else if (dummyPend) dummyPend <= 1'b0;
      end
      if (sprStart) sprCnt <= '0;
      else if (sprGet | sprPut) sprCnt <= sprCnt + 1'b1;
    end
  end

  assign stb = '{entry: entry, smpGo: smpGo, sprGet: sprGet, sprPut: sprPut,
                 align: align, sprStart: sprStart, smpStart: smpStart};
  assign busOwn = entry | active;

  // R3: two data reads never fall on adjacent cycles
  p_reads_split_r3: assert property (@(posedge clk) disable iff (!rstN)
    (smpGo | sprGet) |=> !(smpGo | sprGet));
  // R4: sample completes only on even cycles with both flags spent
  p_smp_flags_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(smpPend) |-> $past(!haltPend && !dummyPend && !cycOdd));
  // R6: done pulse only once the copy is no longer active
  p_done_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    sprDone |-> !sprActive);
  // R9: bus released only with nothing pending
  p_release_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busOwn) |-> (!sprActive && !smpPend));
endmodule

// File: rtl/dma_arb_dp.sv
module dma_arb_dp
  import dma_arb_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int OFF_W    = 8,
  parameter int NUM_SKIP = 2,
  parameter logic [NUM_SKIP*ADDR_W-1:0] SKIP_LIST = {16'h4017, 16'h4016},
  parameter logic [ADDR_W-1:0] SPR_PORT = 16'h2004
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  dmaStrobe_t               stb,
  input  logic [ADDR_W-1:0]        stallAddr,
  input  logic [ADDR_W-OFF_W-1:0]  sprPage,
  input  logic [ADDR_W-1:0]        smpAddr,
  input  logic [DATA_W-1:0]        busRdata,
  output logic                     busRd,
  output logic                     busWr,
  output logic [ADDR_W-1:0]        busAddr,
  output logic [DATA_W-1:0]        busWdata,
  output logic                     smpLoad,
  output logic [DATA_W-1:0]        smpData
);
  localparam int PAGE_W = ADDR_W - OFF_W;

  logic [PAGE_W-1:0] pageQ;
  logic [OFF_W-1:0]  offQ;
  logic [ADDR_W-1:0] smpAddrQ;
  logic [DATA_W-1:0] latchQ;
  logic [NUM_SKIP-1:0] skipHit;
  logic skip;

  for (genvar g = 0; g < NUM_SKIP; g++) begin : gSkip
    assign skipHit[g] = (stallAddr == SKIP_LIST[g*ADDR_W +: ADDR_W]);
  end
  assign skip = |skipHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pageQ    <= '0;
      offQ     <= '0;
      smpAddrQ <= '0;
      latchQ   <= '0;
      smpLoad  <= 1'b0;
      smpData  <= '0;
    end else begin
      smpLoad <= stb.smpGo;
      if (stb.sprStart) begin
        pageQ <= sprPage;
        offQ  <= '0;
      end else if (stb.sprGet) begin
        offQ <= offQ + 1'b1;
      end
      if (stb.sprGet) latchQ <= busRdata;
      if (stb.smpStart) smpAddrQ <= smpAddr;
      if (stb.smpGo) smpData <= busRdata;
    end
  end

  always_comb begin
    busRd = stb.entry | stb.smpGo | stb.sprGet | (stb.align & !skip);
    busWr = stb.sprPut;
    if (stb.smpGo)       busAddr = smpAddrQ;
    else if (stb.sprGet) busAddr = {pageQ, offQ};
    else if (stb.sprPut) busAddr = SPR_PORT;
    else                 busAddr = stallAddr;
    busWdata = latchQ;
  end

  // R5: a put writes the byte fetched by the read just before it
  p_put_data_r5: assert property (@(posedge clk) disable iff (!rstN)
    busWr |-> ($past(busRd) && busWdata == $past(busRdata)));
  // R4: load pulse follows a read of the latched sample address
  p_load_src_r4: assert property (@(posedge clk) disable iff (!rstN)
    smpLoad |-> ($past(busRd) && $past(busAddr) == smpAddrQ && smpData == $past(busRdata)));
endmodule

// File: rtl/dma_arb.sv
module dma_arb
  import dma_arb_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int SPR_LEN  = 256,
  parameter logic [ADDR_W-1:0] SPR_PORT = 16'h2004,
  parameter int NUM_SKIP = 2,
  parameter logic [NUM_SKIP*ADDR_W-1:0] SKIP_LIST = {16'h4017, 16'h4016},
  localparam int OFF_W  = $clog2(SPR_LEN),
  localparam int PAGE_W = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] stallAddr,
  input  logic              sprReq,
  input  logic [PAGE_W-1:0] sprPage,
  input  logic              smpReq,
  input  logic [ADDR_W-1:0] smpAddr,
  output logic              busOwn,
  output logic              busRd,
  output logic              busWr,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] busRdata,
  output logic              sprDone,
  output logic              smpLoad,
  output logic [DATA_W-1:0] smpData
);
  dmaStrobe_t stb;

  dma_arb_ctl #(.SPR_LEN(SPR_LEN)) uCtl (
    .clk(clk), .rstN(rstN), .sprReq(sprReq), .smpReq(smpReq),
    .stb(stb), .busOwn(busOwn), .sprDone(sprDone)
  );

  dma_arb_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W), .NUM_SKIP(NUM_SKIP),
    .SKIP_LIST(SKIP_LIST), .SPR_PORT(SPR_PORT)
  ) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .stallAddr(stallAddr), .sprPage(sprPage),
    .smpAddr(smpAddr), .busRdata(busRdata), .busRd(busRd), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .smpLoad(smpLoad), .smpData(smpData)
  );

  // R1: no bus strobes without ownership
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busOwn |-> (!busRd && !busWr));
endmodule

// File: tb/tb_dma_arb.sv
module tb_dma_arb;
  localparam int CLK_PERIOD = 10;
  localparam int SPR_LEN = 32;
  localparam int OFF_W = $clog2(SPR_LEN);
  localparam int PAGE_W = 16 - OFF_W;
  localparam int K_IDLE = 0, K_ENTRY = 1, K_SMP = 2, K_GET = 3, K_PUT = 4, K_ALIGN = 5;

  logic clk = 1'b0, rstN = 1'b0;
  logic [15:0] stallAddr = 16'h8123;
  logic sprReq = 1'b0, smpReq = 1'b0;
  logic [PAGE_W-1:0] sprPage = '0;
  logic [15:0] smpAddr = '0;
  logic busOwn, busRd, busWr, sprDone, smpLoad;
  logic [15:0] busAddr;
  logic [7:0] busWdata, busRdata, smpData;

  int errors = 0, checks = 0, cycles = 0;
  int wrN = 0, doneN = 0, padReads = 0, loadN = 0;

  // model state
  int mActive = 0, mSpr = 0, mSmp = 0, mHalt = 0, mDummy = 0, mCnt = 0, mOff = 0;
  int mPage = 0, mSmpAddr = 0, mLatch = 0, mPar = 0, mDone = 0, mLoad = 0, mLoadData = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int memf(int a);
    return ((a & 255) ^ ((a >> 8) & 255) ^ 'hA5) & 255;
  endfunction
  assign busRdata = 8'(memf(int'(busAddr)));

  dma_arb #(.SPR_LEN(SPR_LEN)) dut (
    .clk(clk), .rstN(rstN), .stallAddr(stallAddr), .sprReq(sprReq), .sprPage(sprPage),
    .smpReq(smpReq), .smpAddr(smpAddr), .busOwn(busOwn), .busRd(busRd), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .sprDone(sprDone),
    .smpLoad(smpLoad), .smpData(smpData)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cycles);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  // one cycle: inputs already driven after a falling edge
  task automatic tick();
    int kind, eRd, eWr, eAddr, skip, lastPut, startS, startM, nSpr, nSmp;
    #1;
    skip = (int'(stallAddr) == 'h4016 || int'(stallAddr) == 'h4017);
    if (!mActive && (mSpr || mSmp)) kind = K_ENTRY;
    else if (!mActive) kind = K_IDLE;
    else if (mPar == 0 && mSmp && !mHalt && !mDummy) kind = K_SMP;
    else if (mPar == 0 && mSpr) kind = K_GET;
    else if (mPar == 1 && mSpr && (mCnt % 2) == 1) kind = K_PUT;
    else kind = K_ALIGN;
    eRd = (kind == K_ENTRY || kind == K_SMP || kind == K_GET || (kind == K_ALIGN && !skip));
    eWr = (kind == K_PUT);
    case (kind)
      K_SMP:   eAddr = mSmpAddr;
      K_GET:   eAddr = mPage * SPR_LEN + mOff;
      K_PUT:   eAddr = 'h2004;
      default: eAddr = int'(stallAddr);
    endcase
    chk("R9", "busOwn", int'(busOwn), int'(kind != K_IDLE));
    chk("R7", "busRd", int'(busRd), eRd);
    chk("R5", "busWr", int'(busWr), eWr);
    if (eRd || eWr) chk((kind == K_SMP) ? "R4" : (kind == K_GET || kind == K_PUT) ? "R5" : "R2",
                        "busAddr", int'(busAddr), eAddr);
    if (eWr) chk("R5", "busWdata", int'(busWdata), mLatch);
    chk("R6", "sprDone", int'(sprDone), mDone);
    chk("R4", "smpLoad", int'(smpLoad), mLoad);
    if (mLoad) chk("R4", "smpData", int'(smpData), mLoadData);
    if (busWr) wrN++;
    if (sprDone) doneN++;
    if (smpLoad) loadN++;
    if (busRd && skip && busAddr == stallAddr) padReads++;
    // advance model
    lastPut = (kind == K_PUT && mCnt == 2 * SPR_LEN - 1);
    startS = sprReq && !mSpr;
    startM = smpReq && !mSmp;
    nSpr = startS || (mSpr && !lastPut);
    nSmp = startM || (mSmp && kind != K_SMP);
    if (kind == K_GET) begin mLatch = memf(eAddr); mOff++; mCnt++; end
    if (kind == K_PUT) mCnt++;
    if (kind == K_SMP) mLoadData = memf(mSmpAddr);
    mLoad = (kind == K_SMP);
    mDone = lastPut;
    if (startM) begin mHalt = 1; mDummy = 1; mSmpAddr = int'(smpAddr); end
    else if (kind != K_IDLE) begin
      if (mHalt) mHalt = 0; else if (mDummy) mDummy = 0;
    end
    if (startS) begin mCnt = 0; mOff = 0; mPage = int'(sprPage); end
    mActive = ((kind == K_ENTRY) || mActive) && (nSpr || nSmp);
    mSpr = nSpr;
    mSmp = nSmp;
    mPar ^= 1;
    @(negedge clk);
  endtask

  task automatic drain();
    for (int i = 0; i < 2000 && (mActive || mSpr || mSmp); i++) tick();
    repeat (3) tick();
  endtask

  task automatic pulse(bit s, bit m);
    sprReq = s; smpReq = m;
    tick();
    sprReq = 1'b0; smpReq = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "busOwn in reset", int'(busOwn), 0);
    chk("R1", "busRd in reset", int'(busRd), 0);
    chk("R1", "busWr in reset", int'(busWr), 0);
    chk("R1", "sprDone in reset", int'(sprDone), 0);
    chk("R1", "smpLoad in reset", int'(smpLoad), 0);
    rstN = 1'b1;
    repeat (4) tick();

    // R5 R6 R3: sprite copy started on both parities
    for (int want = 0; want < 2; want++) begin
      while (mPar != want) tick();
      wrN = 0; doneN = 0;
      stallAddr = 16'h8123;
      sprPage = PAGE_W'(11'h0A5 + want);
      pulse(1'b1, 1'b0);
      drain();
      chk("R5", "sprite write count", wrN, SPR_LEN);
      chk("R6", "sprDone pulses", doneN, 1);
    end

    // R7 R2 R4: lone sample with stall on controller port
    stallAddr = 16'h4016; smpAddr = 16'hC3F1; padReads = 0; loadN = 0;
    pulse(1'b0, 1'b1);
    drain();
    chk("R7", "controller-port reads (entry only)", padReads, 1);
    chk("R4", "sample loads", loadN, 1);

    // same, entry on the other parity
    stallAddr = 16'h4017; smpAddr = 16'h1234; padReads = 0;
    tick();
    pulse(1'b0, 1'b1);
    drain();
    chk("R2", "entry read at controller port", padReads, 1);

    // R8: sample injected in the middle of a sprite copy
    stallAddr = 16'h4017; sprPage = PAGE_W'(11'h321); smpAddr = 16'h7E02;
    wrN = 0; doneN = 0; loadN = 0;
    pulse(1'b1, 1'b0);
    repeat (20) tick();
    pulse(1'b0, 1'b1);
    drain();
    chk("R8", "sprite writes with sample inside", wrN, SPR_LEN);
    chk("R8", "sample loads inside sprite", loadN, 1);

    // both requests in one cycle
    stallAddr = 16'h9000; sprPage = PAGE_W'(11'h011); smpAddr = 16'h5555;
    wrN = 0; loadN = 0;
    pulse(1'b1, 1'b1);
    drain();
    chk("R8", "sprite writes with joint start", wrN, SPR_LEN);
    chk("R4", "sample loads with joint start", loadN, 1);

    // R9: repeated sprite request while busy is ignored
    stallAddr = 16'h8000; sprPage = PAGE_W'(11'h040); wrN = 0; doneN = 0;
    pulse(1'b1, 1'b0);
    repeat (10) tick();
    sprPage = PAGE_W'(11'h7FF);
    pulse(1'b1, 1'b0);
    drain();
    chk("R9", "writes after repeated request", wrN, SPR_LEN);
    chk("R9", "done pulses after repeated request", doneN, 1);
    chk("R9", "bus released", int'(busOwn), 0);
    chk("R1", "quiet after drain", int'(busRd | busWr), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule